// File: doc/BRIEF.md
# FP16 Vector Mantissa Normalization Unit

This block takes a vector of half-precision (FP16) lanes and, for each lane, returns the significand rescaled into one of four target intervals, with sign handling chosen by an 8-bit control immediate. The fraction bits of the source pass through unchanged. Only the exponent field is rebuilt, so that the value lands in the requested interval. Special inputs (NaN, infinities, zeros, subnormals and negative values under sign control) follow fixed substitution rules. The unit raises an invalid flag and a denormal flag as side results.

Each lane can be selected by a write mask. When masking is enabled, unselected lanes are either cleared (zeroing mode) or keep the old destination value supplied on a port (merge mode). A broadcast flag makes every lane compute from source lane 0. Results and flags are captured into registers on a valid strobe and appear one cycle later. They hold until the next strobe.

Top module: `fp16_mant_norm`

## Requirements
- R1: With interval code imm[1:0]=00 ([1,2)), an ordinary non-negative input gives sign 0, exponent field 15, and the source fraction bits [9:0] unchanged.
- R2: With interval code 10 ([1/2,1)), an ordinary input gives exponent field 14 and keeps the source fraction.
- R3: With interval code 01 ([1/2,2)), the exponent field is 14 when the unbiased source exponent (field minus 15) is odd, and 15 when it is even.
- R4: With interval code 11 ([3/4,3/2)), the exponent field is 14 when source fraction bit 9 is 1, and 15 when it is 0.
- R5: For ordinary results, the sign bit is 0 when sign-control bit imm[2] is 1. Otherwise it is the source sign. A negative ordinary input with imm[3]=0 raises no invalid flag.
- R6: A NaN input (exponent field 31, fraction nonzero) returns the source with fraction bit 9 forced to 1, whatever the interval code. The invalid flag is raised only if source fraction bit 9 was 0.
- R7: +0 and +infinity return 16'h3C00. -0 returns 16'h3C00 when imm[2]=1 and 16'hBC00 otherwise. -infinity with imm[3]=0 follows the same rule as -0. None of these raise a flag.
- R8: When imm[3]=1, any negative input that is not NaN and not zero (including -infinity and negative subnormals) returns 16'hFE00 and raises the invalid flag, but not the denormal flag.
- R9: A subnormal input (exponent field 0, fraction nonzero) is normalized by left-shifting the fraction until its leading one becomes implicit. The unbiased exponent is minus the shift count, and the code-01 parity uses this value. The denormal flag is raised.
- R10: When masking is enabled, only lanes whose mask bit is 1 receive the result. Other lanes become 0 in zeroing mode and the old destination lane in merge mode. Flags are ORed only over selected lanes. When masking is disabled, all lanes are selected.
- R11: With broadcast asserted, every lane computes from source lane 0 (bits [15:0]).
- R12: Results and flags are registered one cycle after a valid strobe and hold while the strobe is low. After reset they are 0. Immediate bits [7:4] have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | VEC_W | Source FP16 lanes, lane i in bits [16i+15:16i] |
| wr_mask | input | VEC_W/16 | Per-lane select |
| mask_en | input | 1 | 1 = apply wr_mask, 0 = all lanes selected |
| zero_mode | input | 1 | 1 = clear unselected lanes, 0 = merge old destination |
| bcast | input | 1 | Replicate source lane 0 to all lanes |
| old_dst | input | VEC_W | Previous destination value for merge |
| imm | input | 8 | [1:0] interval code, [3:2] sign control |
| out_valid | output | 1 | Result registered this cycle |
| res_vec | output | VEC_W | Result lanes |
| flag_inv | output | 1 | Invalid flag of the last operation |
| flag_den | output | 1 | Denormal flag of the last operation |

## Verification
The hardest case to reach from the ports is the subnormal path under the parity interval. The result depends on the exact leading-one position, and an error of one in the shift count flips both the fraction and the exponent choice. Directed operations therefore walk a single set bit, and bit patterns with extra trailing ones, through all ten fraction positions. Random stimulus then mixes subnormal, NaN, zero, infinity and negative classes in every lane under random masks and immediates. A second subtle case is flag suppression in masked-off lanes. A directed operation places invalid-raising and denormal-raising inputs only in unselected lanes and expects both flags to stay low.

// File: rtl/fp16_mant_pkg.sv
package fp16_mant_pkg;
  localparam int FP_W   = 16;
  localparam int EXP_W  = 5;
  localparam int FRAC_W = 10;
  localparam int SH_W   = $clog2(FRAC_W + 1);

  localparam logic [EXP_W-1:0] EXP_MAX  = '1;
  localparam logic [EXP_W-1:0] EXP_B    = 5'd15;
  localparam logic [EXP_W-1:0] EXP_B_M1 = 5'd14;

  localparam logic [FP_W-1:0] FP_POS_ONE = 16'h3C00;
  localparam logic [FP_W-1:0] FP_NEG_ONE = 16'hBC00;
  localparam logic [FP_W-1:0] FP_DEF_NAN = 16'hFE00;

  typedef enum logic [1:0] {
    IV_ONE_TWO   = 2'b00,
    IV_HALF_TWO  = 2'b01,
    IV_HALF_ONE  = 2'b10,
    IV_TQ_THREEH = 2'b11
  } interval_e;
endpackage

// File: rtl/fp16_rst_sync.sv
module fp16_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/fp16_mant_lane.sv
module fp16_mant_lane
  import fp16_mant_pkg::*;
(
  input  logic [FP_W-1:0] x,
  input  interval_e       intv,
  input  logic [1:0]      sc,
  output logic [FP_W-1:0] y,
  output logic            inv,
  output logic            den
);
  logic              s;
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic              is_nan, is_inf, is_zero, is_sub;
  logic [SH_W-1:0]   shamt;
  logic [FRAC_W-1:0] frac_n;
  logic              odd_exp;
  logic [EXP_W-1:0]  exp_o;

  always_comb begin
    s       = x[FP_W-1];
    e       = x[FP_W-2:FRAC_W];
    f       = x[FRAC_W-1:0];
    is_nan  = (e == EXP_MAX) && (f != '0);
    is_inf  = (e == EXP_MAX) && (f == '0);
    is_zero = (e == '0) && (f == '0);
    is_sub  = (e == '0) && (f != '0);

    // shift count that moves the highest set bit out of the fraction field
    shamt = '0;
    for (int k = 0; k < FRAC_W; k++) begin
      if (f[k]) shamt = SH_W'(FRAC_W - k);
    end
    frac_n  = is_sub ? (f << shamt) : f;
    // normal: unbiased = e - 15, odd when e is even; subnormal: unbiased = -shamt
    odd_exp = is_sub ? shamt[0] : ~e[0];

    unique case (intv)
      IV_ONE_TWO:   exp_o = EXP_B;
      IV_HALF_TWO:  exp_o = odd_exp ? EXP_B_M1 : EXP_B;
      IV_HALF_ONE:  exp_o = EXP_B_M1;
      IV_TQ_THREEH: exp_o = frac_n[FRAC_W-1] ? EXP_B_M1 : EXP_B;
      default:      exp_o = EXP_B;
    endcase

    y   = {(sc[0] ? 1'b0 : s), exp_o, frac_n};
    inv = 1'b0;
    den = is_sub;

    if (is_nan) begin
      y   = {s, EXP_MAX, 1'b1, f[FRAC_W-2:0]};
      inv = ~f[FRAC_W-1];
      den = 1'b0;
    end else if (is_zero || is_inf) begin
      den = 1'b0;
      if (!s) begin
        y = FP_POS_ONE;
      end else if (is_inf && sc[1]) begin
        y   = FP_DEF_NAN;
        inv = 1'b1;
      end else begin
        y = sc[0] ? FP_POS_ONE : FP_NEG_ONE;
      end
    end else if (s && sc[1]) begin
      y   = FP_DEF_NAN;
      inv = 1'b1;
      den = 1'b0;
    end
  end
endmodule

// File: rtl/fp16_mant_norm.sv
module fp16_mant_norm
  import fp16_mant_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int LANES = VEC_W / FP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [LANES-1:0] wr_mask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic             bcast,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [7:0]       imm,
  output logic             out_valid,
  output logic [VEC_W-1:0] res_vec,
  output logic             flag_inv,
  output logic             flag_den
);
  logic rst_s_n;

  fp16_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s_n));

  logic [LANES-1:0][FP_W-1:0] lane_x, lane_y, lane_o;
  logic [LANES-1:0]           lane_inv, lane_den, lane_act;
  logic [3:0]                 unused_imm;
  interval_e                  intv;

  assign unused_imm = imm[7:4];
  assign intv       = interval_e'(imm[1:0]);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_x[i]   = bcast ? src_vec[FP_W-1:0] : src_vec[i*FP_W +: FP_W];
    assign lane_act[i] = !mask_en || wr_mask[i];

    fp16_mant_lane u_lane (
      .x   (lane_x[i]),
      .intv(intv),
      .sc  (imm[3:2]),
      .y   (lane_y[i]),
      .inv (lane_inv[i]),
      .den (lane_den[i])
    );

    assign lane_o[i] = lane_act[i] ? lane_y[i] :
                       (zero_mode ? '0 : old_dst[i*FP_W +: FP_W]);

    // R9: one lane never reports both flags
    p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
      !(lane_inv[i] && lane_den[i]));
    // R6: a NaN lane input always leaves quiet
    p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
      ((lane_x[i][14:10] == 5'h1F) && (lane_x[i][9:0] != '0)) |-> lane_y[i][9]);
  end

  logic [VEC_W-1:0] res_d, res_q;
  logic             inv_d, inv_q, den_d, den_q, vld_d, vld_q;

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    inv_d = inv_q;
    den_d = den_q;
    if (in_valid) begin
      res_d = lane_o;
      inv_d = |(lane_inv & lane_act);
      den_d = |(lane_den & lane_act);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
      den_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) begin
        res_q <= res_d;
        inv_q <= inv_d;
        den_q <= den_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign res_vec   = res_q;
  assign flag_inv  = inv_q;
  assign flag_den  = den_q;

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> ($stable(res_vec) && $stable(flag_inv) && $stable(flag_den)));
  p_valid_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> out_valid);
  p_merge_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && mask_en && !zero_mode && !wr_mask[0])
      |=> (res_vec[FP_W-1:0] == $past(old_dst[FP_W-1:0])));
  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && mask_en && zero_mode && !wr_mask[0]) |=> (res_vec[FP_W-1:0] == '0));
endmodule

// File: tb/sim_fp16_mant_norm.sv
module sim_fp16_mant_norm;
  localparam int W = 128;
  localparam int L = W / 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, mask_en, zero_mode, bcast;
  logic [W-1:0] src_vec, old_dst;
  logic [L-1:0] wr_mask;
  logic [7:0]   imm;
  logic         out_valid, flag_inv, flag_den;
  logic [W-1:0] res_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fp16_mant_norm #(.VEC_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .wr_mask(wr_mask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
    .old_dst(old_dst), .imm(imm), .out_valid(out_valid), .res_vec(res_vec),
    .flag_inv(flag_inv), .flag_den(flag_den)
  );

  // returns {inv, den, result}
  function automatic logic [17:0] ref_gm(input logic [15:0] x, input logic [7:0] im);
    logic s; logic [4:0] e; logic [9:0] fr; logic [4:0] eo;
    int ue; logic dn, j, odd;
    s = x[15]; e = x[14:10]; fr = x[9:0];
    if (e == 5'h1F && fr != 0) return {~fr[9], 1'b0, s, 5'h1F, 1'b1, fr[8:0]};
    if (fr == 0 && (e == 0 || e == 5'h1F)) begin
      if (!s) return {2'b00, 16'h3C00};
      if (e == 5'h1F && im[3]) return {2'b10, 16'hFE00};
      return {2'b00, (im[2] ? 16'h3C00 : 16'hBC00)};
    end
    if (s && im[3]) return {2'b10, 16'hFE00};
    dn = 1'b0;
    ue = int'(e) - 15;
    if (e == 0) begin
      dn = 1'b1; ue = 0;
      do begin
        j = fr[9]; fr = fr << 1; ue = ue - 1;
      end while (!j);
    end
    odd = ue[0];
    case (im[1:0])
      2'b00: eo = 5'd15;
      2'b01: eo = odd ? 5'd14 : 5'd15;
      2'b10: eo = 5'd14;
      default: eo = fr[9] ? 5'd14 : 5'd15;
    endcase
    return {1'b0, dn, (im[2] ? 1'b0 : s), eo, fr};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] er, input logic ei, input logic ed);
    n_chk++;
    if (res_vec !== er || flag_inv !== ei || flag_den !== ed || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: res=%h inv=%b den=%b vld=%b expected res=%h inv=%b den=%b vld=1",
               tag, res_vec, flag_inv, flag_den, out_valid, er, ei, ed);
    end
  endtask

  task automatic run_op(input string tag, input logic [W-1:0] s, input logic [L-1:0] m,
                        input logic me, input logic zm, input logic bc,
                        input logic [W-1:0] od, input logic [7:0] im);
    logic [W-1:0] er; logic ei, ed; logic [17:0] r; logic act;
    er = '0; ei = 1'b0; ed = 1'b0;
    for (int i = 0; i < L; i++) begin
      r   = ref_gm(bc ? s[15:0] : s[i*16 +: 16], im);
      act = !me || m[i];
      if (act) begin
        er[i*16 +: 16] = r[15:0]; ei |= r[17]; ed |= r[16];
      end else begin
        er[i*16 +: 16] = zm ? 16'h0 : od[i*16 +: 16];
      end
    end
    @(negedge clk);
    src_vec = s; wr_mask = m; mask_en = me; zero_mode = zm; bcast = bc;
    old_dst = od; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, er, ei, ed);
  endtask

  function automatic logic [W-1:0] rep(input logic [15:0] v);
    return {L{v}};
  endfunction

  function automatic logic [15:0] rnd_lane();
    logic [15:0] v; v = 16'($urandom);
    case ($urandom % 8)
      0: v[14:10] = 5'h00;
      1: v[14:10] = 5'h1F;
      2: v[14:0]  = 15'h0;
      3: v[14:0]  = 15'h7C00;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v, held;
    void'($urandom(32'h5EED_0F16));
    rst_n = 1'b0; in_valid = 1'b0; mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0;
    src_vec = '0; old_dst = '0; wr_mask = '0; imm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (res_vec !== '0 || flag_inv !== 1'b0 || flag_den !== 1'b0 || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 reset: res=%h inv=%b den=%b vld=%b expected all zero",
               res_vec, flag_inv, flag_den, out_valid);
    end

    v = {16'h4A37, 16'h3C01, 16'h7BFF, 16'h0400, 16'h5555, 16'h2E00, 16'h4000, 16'h3FFF};
    run_op("R1 interval 00", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h00);
    run_op("R2 interval 10", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h02);
    run_op("R3 interval 01 parity", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h01);
    run_op("R4 interval 11 frac bit9", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h03);
    run_op("R12 upper imm ignored", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'hF1);
    v = {16'hCA37, 16'hBC01, 16'hFBFF, 16'h8400, 16'hD555, 16'hAE00, 16'h4000, 16'hBFFF};
    run_op("R5 sign kept", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h01);
    run_op("R5 sign forced", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h07);
    run_op("R8 negative to NaN", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h08);
    v = {16'h7C01, 16'hFDFF, 16'h7E00, 16'hFF55, 16'h7C01, 16'h7E01, 16'h7E01, 16'h7E01};
    run_op("R6 NaN signaling", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h0B);
    v = {L/2{16'h7E01, 16'hFE55}};
    run_op("R6 NaN quiet", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h03);
    v = {16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h0000, 16'h8000, 16'h7C00, 16'hFC00};
    run_op("R7 zero inf sc00", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h00);
    run_op("R7 zero inf sc01", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h06);
    run_op("R8 neg inf sc1", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'h0C);

    for (int p = 0; p < 10; p++) begin
      for (int im = 0; im < 4; im++) begin
        v = rep(16'(1 << p));
        v[31:16] = 16'(10'h3FF >> (9 - p));
        v[47:32] = 16'h8000 | 16'(1 << p);
        run_op("R9 subnormal walk", v, '0, 1'b0, 1'b0, 1'b0, '0, 8'(im));
      end
    end
    run_op("R8 neg subnormal sc1", rep(16'h8123), '0, 1'b0, 1'b0, 1'b0, '0, 8'h09);

    v = {16'h0001, 16'hC000, 16'h3800, 16'h7C01, 16'h4400, 16'h0010, 16'hBC00, 16'h3C00};
    run_op("R10 merge", v, 8'b1010_0101, 1'b1, 1'b0, 1'b0, {L{16'hA5A5}}, 8'h08);
    run_op("R10 zeroing", v, 8'b1010_0101, 1'b1, 1'b1, 1'b0, {L{16'hA5A5}}, 8'h08);
    run_op("R10 flags masked off", v, 8'b0010_1000, 1'b1, 1'b0, 1'b0, {L{16'h1234}}, 8'h08);
    run_op("R10 mask disabled", v, 8'h00, 1'b0, 1'b1, 1'b0, {L{16'h1234}}, 8'h08);
    run_op("R11 broadcast", {{7{16'h4400}}, 16'h0003}, '0, 1'b0, 1'b0, 1'b1, '0, 8'h01);
    run_op("R11 broadcast masked", {{7{16'h0001}}, 16'hC200}, 8'h0F, 1'b1, 1'b1, 1'b1, '0, 8'h0D);

    held = res_vec;
    @(negedge clk);
    src_vec = ~src_vec; imm = 8'h0A; old_dst = ~old_dst;
    repeat (2) @(negedge clk);
    n_chk++;
    if (res_vec !== held || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 hold: res=%h vld=%b expected res=%h vld=0", res_vec, out_valid, held);
    end

    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < L; i++) v[i*16 +: 16] = rnd_lane();
      run_op("R1-style random mix", v, 8'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 6 == 0), {4{32'($urandom)}}, 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule